// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block collects interrupt requests for a 16550-style serial port and reports the most urgent one to software. There are five request sources. Each one has a pending flag, which is set and cleared by one-cycle pulses from the surrounding receive, transmit and modem logic. A four-bit enable register masks the pending flags. A fixed priority encoder turns the surviving requests into an identification code, and software reads that code through the identification register. The block drives one interrupt line, and that line is gated by the OUT2 modem-control output.

The block also has three side effects that software relies on. Writing the transmit holding register cancels a transmit-empty request. Reading the identification register while it shows transmit-empty also cancels that request. Writing the enable register with the transmit bit set while the transmit FIFO is empty raises the transmit-empty request again. When FIFOs are active, the receive-data enable bit also enables the receive-timeout source.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset every pending flag and every enable bit is zero, the identification byte reads 0x01 and `irq` is low.
- R2: Among enabled pending requests, the reported one follows this order, most urgent first: line-status error (source 0), receive timeout (source 1), receive data (source 2), transmit empty (source 3), modem status (source 4).
- R3: Identification bits 3:0 read 0110 for line status, 1100 for timeout, 0100 for receive data, 0010 for transmit empty, 0000 for modem status and 0001 when no enabled request is pending.
- R4: Identification bits 7:6 read 11 while `fifo_en` is high and 00 otherwise. Bits 5:4 always read 0.
- R5: The enable register keeps only bits 3:0 of a write, and bits 7:4 read as zero. Bit 0 enables receive data, bit 1 enables transmit empty, bit 2 enables line status and bit 3 enables modem status.
- R6: The timeout source is enabled only when enable bit 0 is set and `fifo_en` is high.
- R7: An identification read strobe that finds code 0010 clears the transmit-empty flag. A read that finds any other code leaves that flag pending.
- R8: An enable-register write with bit 1 set while `tx_fifo_empty` is high makes the transmit-empty flag pending.
- R9: A `thr_wr` strobe clears the transmit-empty flag.
- R10: `irq` is high exactly when some enabled request is pending and `out2` is high.
- R11: A clear pulse drops its source's flag. When a set pulse and a clear for the same source arrive together, the flag ends up set.
- R12: Masking does not discard a request. A flag that is pending while disabled is reported as soon as its enable bit is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_pulse | input | 5 | Per-source set pulse (index = source number) |
| clr_pulse | input | 5 | Per-source clear pulse |
| fifo_en | input | 1 | FIFOs active |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no data |
| out2 | input | 1 | OUT2 gate for the interrupt line |
| ier_wr | input | 1 | Enable-register write strobe |
| ier_wdata | input | 8 | Enable-register write data |
| ier_rdata | output | 8 | Enable-register read value |
| iir_rd | input | 1 | Identification-register read strobe |
| iir_rdata | output | 8 | Identification-register read value |
| thr_wr | input | 1 | Transmit holding register write strobe |
| irq | output | 1 | Interrupt request line |

## Verification
The assertions check on every cycle the things that can be seen locally:
- OUT2 gating of `irq`, and agreement between `irq` and the "nothing pending" code.
- The FIFO status bits and the zero upper enable bits.
- That a set pulse always leaves its flag pending.
- That a THR write or a read-acknowledge removes the transmit-empty code on the next cycle.

The full priority mapping over every pending pattern, every enable value and both FIFO modes is shown only by the bench sweep. The same holds for the re-arm on an enable write, for requests that were masked and then unmasked, and for reads that must not clear.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 5;
  localparam int SRC_LS = 0;
  localparam int SRC_TO = 1;
  localparam int SRC_RX = 2;
  localparam int SRC_TX = 3;
  localparam int SRC_MS = 4;

  localparam logic [3:0] ID_LS   = 4'b0110;
  localparam logic [3:0] ID_TO   = 4'b1100;
  localparam logic [3:0] ID_RX   = 4'b0100;
  localparam logic [3:0] ID_TX   = 4'b0010;
  localparam logic [3:0] ID_MS   = 4'b0000;
  localparam logic [3:0] ID_NONE = 4'b0001;

  // Enable register bit positions (software-visible)
  localparam int EN_RX = 0;
  localparam int EN_TX = 1;
  localparam int EN_LS = 2;
  localparam int EN_MS = 3;

  // Map the stored enable bits to per-source enables; timeout follows RX when FIFOs run.
  function automatic logic [NSRC-1:0] src_enables(input logic [3:0] ier, input logic fifo_on);
    logic [NSRC-1:0] e;
    e[SRC_LS] = ier[EN_LS];
    e[SRC_TO] = ier[EN_RX] & fifo_on;
    e[SRC_RX] = ier[EN_RX];
    e[SRC_TX] = ier[EN_TX];
    e[SRC_MS] = ier[EN_MS];
    return e;
  endfunction

  function automatic logic [3:0] id_of(input logic [NSRC-1:0] act);
    logic [3:0] id;
    id = ID_NONE;
    if      (act[SRC_LS]) id = ID_LS;
    else if (act[SRC_TO]) id = ID_TO;
    else if (act[SRC_RX]) id = ID_RX;
    else if (act[SRC_TX]) id = ID_TX;
    else if (act[SRC_MS]) id = ID_MS;
    return id;
  endfunction
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        pend[i] <= 1'b0;
      else if (set_v[i]) pend[i] <= 1'b1;
      else if (clr_v[i]) pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int DW = 8,
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [EW-1:0] ier_q,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)  ier_q <= '0;
    else if (wr) ier_q <= wdata[EW-1:0];
  end
  assign rdata = {{(DW-EW){1'b0}}, ier_q};
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] act,
  output logic [3:0]      id,
  output logic            any
);
  assign id  = id_of(act);
  assign any = |act;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_pulse,
  input  logic [NSRC-1:0] clr_pulse,
  input  logic            fifo_en,
  input  logic            tx_fifo_empty,
  input  logic            out2,
  input  logic            ier_wr,
  input  logic [DW-1:0]   ier_wdata,
  output logic [DW-1:0]   ier_rdata,
  input  logic            iir_rd,
  output logic [DW-1:0]   iir_rdata,
  input  logic            thr_wr,
  output logic            irq
);
  localparam int EW = 4;

  logic [EW-1:0]   ier_q;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] eff_en;
  logic [NSRC-1:0] active;
  logic [3:0]      cur_id;
  logic            any_act;
  logic            tx_rearm;
  logic            tx_ack;
  logic [NSRC-1:0] set_all;
  logic [NSRC-1:0] clr_all;

  irq_enable_reg #(.DW(DW), .EW(EW)) u_ier (
    .clk(clk), .rst_n(rst_n), .wr(ier_wr), .wdata(ier_wdata),
    .ier_q(ier_q), .rdata(ier_rdata)
  );

  assign tx_rearm = ier_wr && ier_wdata[EN_TX] && tx_fifo_empty;
  assign tx_ack   = iir_rd && (cur_id == ID_TX);

  always_comb begin
    set_all = set_pulse;
    clr_all = clr_pulse;
    set_all[SRC_TX] = set_pulse[SRC_TX] | tx_rearm;
    clr_all[SRC_TX] = clr_pulse[SRC_TX] | thr_wr | tx_ack;
  end

  irq_pending #(.N(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_v(set_all), .clr_v(clr_all), .pend(pend_q)
  );

  assign eff_en = src_enables(ier_q, fifo_en);
  assign active = pend_q & eff_en;

  irq_prio_enc u_enc (.act(active), .id(cur_id), .any(any_act));

  assign iir_rdata = {{2{fifo_en}}, {(DW-6){1'b0}}, cur_id};
  assign irq       = any_act & out2;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
  import uart_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] set_pulse,
  input logic            fifo_en,
  input logic            out2,
  input logic [DW-1:0]   ier_rdata,
  input logic            iir_rd,
  input logic [DW-1:0]   iir_rdata,
  input logic            thr_wr,
  input logic            irq,
  input logic [NSRC-1:0] pend_q
);
  a_r10_out2_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !out2 |-> !irq);
  a_r10_irq_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> iir_rdata[3:0] != ID_NONE);
  a_r4_fifo_bits: assert property (@(posedge clk) disable iff (!rst_n)
    iir_rdata[7:4] == {fifo_en, fifo_en, 2'b00});
  a_r5_ier_upper: assert property (@(posedge clk) disable iff (!rst_n)
    ier_rdata[DW-1:4] == '0);
  a_r9_thr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !set_pulse[SRC_TX]) |=> !pend_q[SRC_TX]);
  a_r7_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir_rdata[3:0] == ID_TX && !set_pulse[SRC_TX]) |=> !pend_q[SRC_TX]);
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_pulse) |=> ((pend_q & $past(set_pulse)) == $past(set_pulse)));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] set_pulse = '0, clr_pulse = '0;
  logic       fifo_en = 1'b0, tx_fifo_empty = 1'b0, out2 = 1'b0;
  logic       ier_wr = 1'b0, iir_rd = 1'b0, thr_wr = 1'b0;
  logic [7:0] ier_wdata = '0;
  logic [7:0] ier_rdata, iir_rdata;
  logic       irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_irq_ident dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Expected identification byte, derived from the requirement tables.
  function automatic int exp_iir(input int p, input int ier, input int fe);
    int en, a;
    int codes[5] = '{6, 12, 4, 2, 0};
    en = (((ier >> 2) & 1) << 0) | (((ier & 1) & fe) << 1) | ((ier & 1) << 2)
       | (((ier >> 1) & 1) << 3) | (((ier >> 3) & 1) << 4);
    a = p & en;
    exp_iir = (fe ? 8'hC0 : 0);
    for (int k = 0; k < 5; k++)
      if ((a >> k) & 1) return exp_iir + codes[k];
    return exp_iir + 1;
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_wr = 1; ier_wdata = v; tick(); ier_wr = 0;
  endtask

  task automatic load(input logic [4:0] p);
    clr_pulse = 5'h1f; tick(); clr_pulse = 0;
    set_pulse = p; tick(); set_pulse = 0;
  endtask

  initial begin
    tick(); tick(); tick();
    rst_n = 1; #1;
    chk("R1 iir", iir_rdata, 8'h01);
    chk("R1 ier", ier_rdata, 0);
    out2 = 1; #1;
    chk("R1 irq", irq, 0);
    tick();

    // R2 R3 R4 R5 R6 R10 sweep
    for (int fe = 0; fe < 2; fe++)
      for (int ie = 0; ie < 16; ie++)
        for (int p = 0; p < 32; p++) begin
          fifo_en = fe[0];
          wr_ier({4'hA, ie[3:0]});
          load(p[4:0]);
          out2 = 1; #1;
          chk("R2/R3/R4/R6 iir", iir_rdata, exp_iir(p, ie, fe));
          chk("R5 ier", ier_rdata, ie);
          chk("R10 irq out2=1", irq, exp_iir(p, ie, fe) % 2 == 0);
          out2 = 0; #1;
          chk("R10 irq out2=0", irq, 0);
        end

    fifo_en = 0; out2 = 1;
    // R12: pending while masked, then unmasked
    wr_ier(8'h00); load(5'b10000); #1;
    chk("R12 masked", iir_rdata, 8'h01);
    wr_ier(8'h08); #1;
    chk("R12 unmasked", iir_rdata, 8'h00);

    // R7: read showing TX clears it
    wr_ier(8'h02); load(5'b01000); #1;
    chk("R7 shows tx", iir_rdata, 8'h02);
    iir_rd = 1; tick(); iir_rd = 0; #1;
    chk("R7 tx cleared", iir_rdata, 8'h01);
    // R7: read showing RX must not clear TX
    wr_ier(8'h03); load(5'b01100); #1;
    chk("R7 shows rx", iir_rdata, 8'h04);
    iir_rd = 1; tick(); iir_rd = 0;
    clr_pulse = 5'b00100; tick(); clr_pulse = 0; #1;
    chk("R7 tx kept", iir_rdata, 8'h02);

    // R9: THR write clears TX
    thr_wr = 1; tick(); thr_wr = 0; #1;
    chk("R9 thr clear", iir_rdata, 8'h01);

    // R8: re-arm on IER write with empty FIFO; no re-arm when not empty
    tx_fifo_empty = 0; wr_ier(8'h02); #1;
    chk("R8 no rearm", iir_rdata, 8'h01);
    tx_fifo_empty = 1; wr_ier(8'h02); #1;
    chk("R8 rearm", iir_rdata, 8'h02);
    tx_fifo_empty = 0;

    // R11: same-source set and clear together -> set
    load(5'b00000); wr_ier(8'h0F);
    set_pulse = 5'b10000; clr_pulse = 5'b10000; tick();
    set_pulse = 0; clr_pulse = 0; #1;
    chk("R11 set wins", iir_rdata, 8'h00);
    clr_pulse = 5'b10000; tick(); clr_pulse = 0; #1;
    chk("R11 clear", iir_rdata, 8'h01);
    // R11: clear of other source while another is set
    load(5'b00001);
    set_pulse = 5'b10000; clr_pulse = 5'b00001; tick();
    set_pulse = 0; clr_pulse = 0; #1;
    chk("R11 cross", iir_rdata, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule